// File: doc/BRIEF.md
# Four-Pin Local/Remote GPIO Output Controller

This block decides, for each of four general-purpose pins, who drives it. A pin can carry a value programmed locally, or a value that a remote link partner sends over the link. It can also be released to high impedance. The last pin can further be switched into an input. The block holds a small configuration bank per pin. The bank loads all fields in one write strobe and comes out of reset in a defined state. The block produces an output-enable and an output value for each pad.

Remote pin values arrive as plain levels from the link logic and are captured in a register. A link change therefore reaches the pad one clock later. Pad input levels are asynchronous to the block clock. They pass through a two-stage synchronizer before they are presented as readable status. The pad cells and the link that carries remote values sit outside this block. All ports are plain control and status levels; no data stream crosses the block edge, so there is no valid/ready handshake.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset, pins 0, 1 and 2 have output-enable 1 and drive the remote value, which resets to 0. Pin 3 has output-enable 0, because after reset it is enabled, not remote-driven, and set to input.
- R2: A pin whose enable bit is 0 has output-enable 0 and output value 0, whatever its other configuration bits and its remote value are.
- R3: An enabled pin whose remote-enable bit is 1 has output-enable 1. It drives the remote value that was present on `rem_in` at the previous rising clock edge.
- R4: An enabled pin 0, 1 or 2 whose remote-enable bit is 0 has output-enable 1 and drives its local value bit.
- R5: Pin 3 has a direction bit, where 1 means input and 0 means output. When pin 3 is enabled and remote-enable is 0, direction 1 gives output-enable 0 and output 0. Direction 0 drives the local value.
- R6: On pin 3, remote-enable 1 overrides the direction bit. The pin drives the remote value even when the direction bit is 1.
- R7: `pad_status[i]` equals the level that `pad_in[i]` had at the rising edge two edges earlier. After only one edge it still shows the older level.
- R8: When `cfg_we` is 1 at a rising edge, the block loads all configuration fields at once. Bit i of `cfg_en`, `cfg_rem` and `cfg_val` belongs to pin i, and `cfg_dir` belongs to pin 3. The new setting shows on the pads right after that edge. When `cfg_we` is 0, the configuration holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for every configuration field |
| cfg_en | input | 4 | Per-pin enable (0 = high impedance) |
| cfg_rem | input | 4 | Per-pin remote-enable |
| cfg_val | input | 4 | Per-pin local output value |
| cfg_dir | input | 1 | Pin 3 direction (1 = input, 0 = output) |
| rem_in | input | 4 | Pin values received from the link partner |
| pad_in | input | 4 | Asynchronous pad input levels |
| pad_oe | output | 4 | Per-pin output-enable |
| pad_out | output | 4 | Per-pin output value, 0 when not driving |
| pad_status | output | 4 | Synchronized pad input levels |

## Verification
The assertions assume that the configuration only changes through a `cfg_we` edge. They also assume that `rem_in` and `pad_in` are stable around the clock edge where they are sampled. Apart from that edge, no ordering between the inputs is assumed. The remote check only compares the pad against the previous `rem_in` once an edge has passed out of reset, so the value that `rem_in` had during reset is never taken for granted. The stimulus changes every input on the falling clock edge only. It sweeps configuration and remote patterns over a thousand-step combinational index, so every field mix appears on every pin.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int unsigned GPM_PINS    = 4;
  localparam int unsigned GPM_DIR_PIN = 3;
  localparam int unsigned GPM_SYNC    = 2;
  localparam logic [GPM_PINS-1:0] GPM_EN_RST  = 4'b1111;
  localparam logic [GPM_PINS-1:0] GPM_REM_RST = 4'b0111;
  localparam logic [GPM_PINS-1:0] GPM_VAL_RST = 4'b0000;
  localparam logic                GPM_DIR_RST = 1'b1;

  typedef enum logic [1:0] {
    DRV_HIZ    = 2'b00,
    DRV_LOCAL  = 2'b01,
    DRV_REMOTE = 2'b10
  } drv_src_e;
endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int unsigned       N       = 4,
  parameter logic [N-1:0]      EN_RST  = '1,
  parameter logic [N-1:0]      REM_RST = '0,
  parameter logic [N-1:0]      VAL_RST = '0,
  parameter logic              DIR_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] en_d,
  input  logic [N-1:0] rem_d,
  input  logic [N-1:0] val_d,
  input  logic         dir_d,
  output logic [N-1:0] en_q,
  output logic [N-1:0] rem_q,
  output logic [N-1:0] val_q,
  output logic         dir_q
);
  for (genvar i = 0; i < N; i++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]  <= EN_RST[i];
        rem_q[i] <= REM_RST[i];
        val_q[i] <= VAL_RST[i];
      end else if (we) begin
        en_q[i]  <= en_d[i];
        rem_q[i] <= rem_d[i];
        val_q[i] <= val_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dir_q <= DIR_RST;
    else if (we) dir_q <= dir_d;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(en_q) && $stable(rem_q) && $stable(val_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] fill_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             fill_q <= '0;
      else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end
    p_two_edge_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == 2'd2) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb
  import gpio_mux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rem,
  input  logic val,
  input  logic as_input,
  input  logic rem_val,
  output logic oe,
  output logic out
);
  drv_src_e src;

  always_comb begin
    if (!en)           src = DRV_HIZ;
    else if (rem)      src = DRV_REMOTE;
    else if (as_input) src = DRV_HIZ;
    else               src = DRV_LOCAL;
  end

  always_comb begin
    unique case (src)
      DRV_REMOTE: begin oe = 1'b1; out = rem_val; end
      DRV_LOCAL:  begin oe = 1'b1; out = val;     end
      default:    begin oe = 1'b0; out = 1'b0;    end
    endcase
  end

  p_tristate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!oe && !out));
  p_remote_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rem) |-> (oe && out == rem_val));
  p_local_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rem && !as_input) |-> (oe && out == val));
  p_input_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rem && as_input) |-> !oe);
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [GPM_PINS-1:0] cfg_en,
  input  logic [GPM_PINS-1:0] cfg_rem,
  input  logic [GPM_PINS-1:0] cfg_val,
  input  logic                cfg_dir,
  input  logic [GPM_PINS-1:0] rem_in,
  input  logic [GPM_PINS-1:0] pad_in,
  output logic [GPM_PINS-1:0] pad_oe,
  output logic [GPM_PINS-1:0] pad_out,
  output logic [GPM_PINS-1:0] pad_status
);
  logic [GPM_PINS-1:0] en_q, rem_q, val_q, link_q;
  logic                dir_q;
  logic                up_q;

  gpio_cfg_bank #(
    .N(GPM_PINS), .EN_RST(GPM_EN_RST), .REM_RST(GPM_REM_RST),
    .VAL_RST(GPM_VAL_RST), .DIR_RST(GPM_DIR_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .en_d(cfg_en), .rem_d(cfg_rem), .val_d(cfg_val), .dir_d(cfg_dir),
    .en_q(en_q), .rem_q(rem_q), .val_q(val_q), .dir_q(dir_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      up_q   <= 1'b0;
    end else begin
      link_q <= rem_in;
      up_q   <= 1'b1;
    end
  end

  for (genvar i = 0; i < GPM_PINS; i++) begin : g_pin
    logic as_input;
    if (i == GPM_DIR_PIN) begin : g_dir
      assign as_input = dir_q;
    end else begin : g_fixed
      assign as_input = 1'b0;
    end

    gpio_pin_arb u_arb (
      .clk(clk), .rst_n(rst_n),
      .en(en_q[i]), .rem(rem_q[i]), .val(val_q[i]), .as_input(as_input),
      .rem_val(link_q[i]), .oe(pad_oe[i]), .out(pad_out[i])
    );

    p_remote_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && en_q[i] && rem_q[i]) |-> (pad_oe[i] && pad_out[i] == $past(rem_in[i])));
  end

  gpio_in_sync #(.N(GPM_PINS), .STAGES(GPM_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_status)
  );

  p_reset_dir_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !up_q |-> (pad_oe == 4'b0111));
endmodule

// File: tb/test_gpio_mux_ctrl.sv
`timescale 1ns/1ps
module test_gpio_mux_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_en = '0, cfg_rem = '0, cfg_val = '0, rem_in = '0, pad_in = '0;
  logic       cfg_dir = 1'b0;
  logic [3:0] pad_oe, pad_out, pad_status;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_ctrl i_gpio_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_rem(cfg_rem), .cfg_val(cfg_val), .cfg_dir(cfg_dir),
    .rem_in(rem_in), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_status(pad_status)
  );

  function automatic logic [1:0] expect_pin(int p, logic en, logic rem, logic val,
                                            logic dir, logic rv);
    if (!en)                 return 2'b00;
    if (rem)                 return {1'b1, rv};
    if (p == 3 && dir)       return 2'b00;
    return {1'b1, val};
  endfunction

  function automatic string req_of(int p, logic en, logic rem, logic dir);
    if (!en)            return "R2";
    if (rem && p == 3 && dir) return "R6";
    if (rem)            return "R3";
    if (p == 3)         return "R5";
    return "R4";
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_pins(logic [3:0] en, logic [3:0] rem, logic [3:0] val,
                            logic dir, logic [3:0] rv, string tag);
    for (int p = 0; p < 4; p++) begin
      logic [1:0] e;
      e = expect_pin(p, en[p], rem[p], val[p], dir, rv[p]);
      check(req_of(p, en[p], rem[p], dir), {2'b00, pad_oe[p], pad_out[p]},
            {2'b00, e}, $sformatf("%s pin%0d oe/out", tag, p));
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev_in;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rem_in = 4'b1111;
    // R1: reset state, remote register still 0
    check("R1", pad_oe, 4'b0111, "reset oe");
    check("R1", pad_out, 4'b0000, "reset out");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // R3: remote value captured one edge after release
    check("R3", pad_out, 4'b0111, "remote after first edge");
    check("R1", pad_oe, 4'b0111, "pin3 still input");

    // R8 / R2..R6 sweep
    for (int i = 0; i < 1024; i++) begin
      logic [3:0] en, rem, val, rv;
      logic dir;
      en  = i[3:0] | {3'b000, i[9]};
      rem = i[7:4];
      val = i[3:0] ^ i[7:4] ^ {i[9:8], i[9:8]};
      dir = i[8];
      rv  = {i[6:4], i[9]} ^ i[3:0];
      cfg_en = en; cfg_rem = rem; cfg_val = val; cfg_dir = dir; rem_in = rv;
      cfg_we = 1'b1;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      check_pins(en, rem, val, dir, rv, "R8 load");
      // R3: remote change visible only after the next edge; R8: cfg held while we=0
      cfg_en = ~en; cfg_rem = ~rem; cfg_val = ~val; cfg_dir = ~dir;
      rem_in = ~rv;
      #1;
      check_pins(en, rem, val, dir, rv, "R3 before edge");
      @(posedge clk); @(negedge clk);
      check_pins(en, rem, val, dir, ~rv, "R3 after edge");
    end

    // R7: synchronizer depth
    prev_in = pad_in;
    for (int v = 0; v < 16; v++) begin
      pad_in = v[3:0];
      @(posedge clk); @(negedge clk);
      check("R7", pad_status, prev_in, "status after one edge");
      @(posedge clk); @(negedge clk);
      check("R7", pad_status, v[3:0], "status after two edges");
      prev_in = v[3:0];
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule